// File: doc/BRIEF.md
# Eight-bit timer/counter with compare unit and phase-correct PWM

This block is an 8-bit counter that advances on ticks taken either from a free-running 10-bit prescaler or from edges on an external event pin. A single compare register is matched against the counter. Depending on the selected mode, the counter free-runs and wraps, reloads to zero on a compare match, toggles a waveform output on each match to generate a frequency, or sweeps up and down for phase-correct pulse-width modulation. Overflow and compare-match events set sticky flags. Each flag has a mask bit, and a request output is raised when both are set.

Software reaches the block through a single-cycle register write strobe. There is no stream interface. The write port takes one write per cycle and never back-pressures. The counter, the waveform, the flags and the requests are plain status outputs.

Top module: `tmr_pwm8`

## Requirements
- R1: After reset the count is 0, the waveform output is 0, both flags and both requests are 0, clock select is 0 (stopped), the mode is 0, and the compare value is 0.
- R2: Clock select field values 1, 2, 3, 4 and 5 advance the counter once every 1, 8, 64, 256 and 1024 clock cycles. The ticks come from a 10-bit prescaler that starts at 0 after reset and increments every cycle. A tick occurs in the cycle where the prescaler's low 0, 3, 6, 8 or 10 bits are all ones. Value 0 stops the counter, and it holds its value.
- R3: Clock select 6 counts falling edges of the external pin and 7 counts rising edges. The pin passes two synchronizer flops and an edge detector. Each edge gives exactly one count, which appears at the third rising clock edge after the pin changes.
- R4: In mode 0 (free-running), each tick increments the count. The tick taken at 0xFF wraps the count to 0 and sets the overflow flag.
- R5: In every mode, a tick taken while the count equals the active compare value sets the compare flag.
- R6: In mode 1 (auto reload), a matching tick loads 0 instead of incrementing, and that tick does not set overflow.
- R7: Mode 2 (frequency output) reloads the counter like mode 1 and also inverts the waveform output on every matching tick.
- R8: In mode 3 (phase-correct), the count rises to 0xFF and then falls to 0, with each extreme held for a single tick. The tick taken at 0 while falling sets the overflow flag.
- R9: In mode 3, a match while rising drives the waveform output to 0, and a match while falling drives it to 1. In modes 0 and 1 the output holds its value.
- R10: In mode 3, a compare write goes to a buffer, and the buffer is copied to the active compare value on the tick taken at 0xFF while rising. In the other modes a compare write takes effect on the next clock.
- R11: Writing a 1 to a flag bit clears that flag, unless the same cycle sets it. Each request output equals its flag AND its mask bit.
- R12: A write to the count register loads the count on the next clock and cancels any tick in that cycle.
- R13: The register addresses are 0 control (bits 2:0 clock select, bits 4:3 mode), 1 count, 2 compare, 3 flags and 4 mask. In the flags and mask registers, bit 0 is overflow and bit 1 is compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ext_evt | input | 1 | External event pin, asynchronous |
| count_o | output | 8 | Current counter value |
| wave_o | output | 1 | Waveform output |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_irq_o | output | 1 | Overflow request (flag and mask) |
| cmp_irq_o | output | 1 | Compare request (flag and mask) |

## Verification
A register write or a prescaler tick shows its effect on the count, the flags and the waveform one rising edge later. The requests follow the flags within the same cycle. An external pin transition reaches the count on the third rising edge after it. The bench runs a behavioural model that steps on every rising edge. It drives inputs just after the falling edge and compares all six outputs against the model at each falling edge, so every result is sampled half a cycle after the edge that produced it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_RELOAD = 2'd1,
    MD_TOGGLE = 2'd2,
    MD_PCPWM  = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_CMP   = 3'd2;
  localparam logic [2:0] A_FLAG  = 3'd3;
  localparam logic [2:0] A_MASK  = 3'd4;

  localparam logic [2:0] CS_OFF      = 3'd0;
  localparam logic [2:0] CS_EXT_FALL = 3'd6;
  localparam logic [2:0] CS_EXT_RISE = 3'd7;

  typedef struct packed {
    logic cmp;
    logic ovf;
  } tmr_evt_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_rise,
  input  logic       ext_fall,
  output logic       tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] tap_mask;

  function automatic int unsigned low_bits(input logic [2:0] s);
    case (s)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + {{(PW-1){1'b0}}, 1'b1};
  end

  always_comb begin
    tap_mask = ~({PW{1'b1}} << low_bits(sel));
    case (sel)
      CS_OFF:      tick = 1'b0;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = &(pre_q | ~tap_mask);
    endcase
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  tmr_mode_e     mode,
  input  logic          cnt_wr,
  input  logic          cmp_wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cmp_act,
  output logic          dn_q,
  output logic          wave_q,
  output tmr_evt_t      evt
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [CW-1:0] BOT = '0;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cmp_buf, cnt_nx;
  logic adv, match, pwm, at_top, at_bot, reload;

  assign pwm    = (mode == MD_PCPWM);
  assign adv    = tick & ~cnt_wr;
  assign match  = adv && (cnt_q == cmp_act);
  assign at_top = pwm && !dn_q && (cnt_q == TOP);
  assign at_bot = pwm &&  dn_q && (cnt_q == BOT);
  assign reload = (mode == MD_RELOAD) || (mode == MD_TOGGLE);

  always_comb begin
    if (cnt_wr)      cnt_nx = wdata;
    else if (!tick)  cnt_nx = cnt_q;
    else if (pwm) begin
      if (dn_q) cnt_nx = (cnt_q == BOT) ? cnt_q + ONE : cnt_q - ONE;
      else      cnt_nx = (cnt_q == TOP) ? cnt_q - ONE : cnt_q + ONE;
    end
    else if (reload && match) cnt_nx = BOT;
    else                      cnt_nx = cnt_q + ONE;
  end

  always_comb begin
    evt.cmp = match;
    if (pwm) evt.ovf = adv && at_bot;
    else     evt.ovf = adv && (cnt_q == TOP) && !(reload && match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_buf <= '0;
      cmp_act <= '0;
      dn_q    <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      if (cmp_wr) cmp_buf <= wdata;
      if (cmp_wr && !pwm)    cmp_act <= wdata;
      else if (adv && at_top) cmp_act <= cmp_buf;
      if (!pwm)               dn_q <= 1'b0;
      else if (adv && at_top) dn_q <= 1'b1;
      else if (adv && at_bot) dn_q <= 1'b0;
      if (match) begin
        if (mode == MD_TOGGLE)  wave_q <= ~wave_q;
        else if (pwm)           wave_q <= dn_q;
      end
    end
  end
endmodule

// File: rtl/tmr_pwm8.sv
module tmr_pwm8
  import tmr_pkg::*;
#(
  parameter int CW   = 8,
  parameter int PW   = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          ext_evt,
  output logic [CW-1:0] count_o,
  output logic          wave_o,
  output logic          ovf_flag_o,
  output logic          cmp_flag_o,
  output logic          ovf_irq_o,
  output logic          cmp_irq_o
);
  logic [2:0] sel_q;
  tmr_mode_e  mode_q;
  tmr_evt_t   flag_q, mask_q, evt, clr;
  logic       ext_rise, ext_fall, cen, cnt_dn;
  logic [CW-1:0] cmp_act;

  logic wr_ctrl, wr_cnt, wr_cmp, wr_flag, wr_mask;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == A_COUNT);
  assign wr_cmp  = wr_en && (wr_addr == A_CMP);
  assign wr_flag = wr_en && (wr_addr == A_FLAG);
  assign wr_mask = wr_en && (wr_addr == A_MASK);
  assign clr     = wr_flag ? tmr_evt_t'(wr_data[1:0]) : tmr_evt_t'(2'b00);

  tmr_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_evt), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_q),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .tick(cen)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(cen), .mode(mode_q),
    .cnt_wr(wr_cnt), .cmp_wr(wr_cmp), .wdata(wr_data),
    .cnt_q(count_o), .cmp_act(cmp_act), .dn_q(cnt_dn),
    .wave_q(wave_o), .evt(evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= CS_OFF;
      mode_q <= MD_NORMAL;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q  <= wr_data[2:0];
        mode_q <= tmr_mode_e'(wr_data[4:3]);
      end
      if (wr_mask) mask_q <= tmr_evt_t'(wr_data[1:0]);
      flag_q <= (flag_q & ~clr) | evt;
    end
  end

  assign ovf_flag_o = flag_q.ovf;
  assign cmp_flag_o = flag_q.cmp;
  assign ovf_irq_o  = flag_q.ovf & mask_q.ovf;
  assign cmp_irq_o  = flag_q.cmp & mask_q.cmp;
endmodule

// File: rtl/tmr_pwm8_chk.sv
module tmr_pwm8_chk
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] count_o,
  input logic          wave_o,
  input logic          ovf_flag_o,
  input logic [2:0]    sel_q,
  input tmr_mode_e     mode_q,
  input logic          cen,
  input logic [CW-1:0] cmp_act,
  input logic          cnt_dn
);
  logic no_cw;
  assign no_cw = !(wr_en && wr_addr == A_COUNT);

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == CS_OFF && no_cw) |=> $stable(count_o));

  p_norm_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_NORMAL && cen && no_cw) |=> count_o == $past(count_o) + 1'b1);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_RELOAD || mode_q == MD_TOGGLE) && cen && no_cw && count_o == cmp_act)
      |=> count_o == '0);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TOGGLE && cen && no_cw && count_o == cmp_act) |=> wave_o != $past(wave_o));

  p_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PCPWM && cen && no_cw && cnt_dn && count_o == '0)
      |=> (count_o == 1 && ovf_flag_o));

  p_cmp_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CMP && mode_q != MD_PCPWM) |=> cmp_act == $past(wr_data));

  p_flag_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_FLAG && wr_data[0] && !cen) |=> !ovf_flag_o);
endmodule

bind tmr_pwm8 tmr_pwm8_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_tmr_pwm8.sv
`timescale 1ns/1ps
module tb_tmr_pwm8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ext_evt = 1'b0;
  logic [7:0] count_o;
  logic wave_o, ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o;

  always #4 clk = ~clk;

  tmr_pwm8 dut (.*);

  int n_vec = 0;
  int n_bad = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_act, m_buf, m_sel, m_mode, m_pre;
  bit m_dn, m_wave, m_fo, m_fc, m_mo, m_mc;
  bit p1, p2, p3;

  task automatic model_reset();
    m_cnt = 0; m_act = 0; m_buf = 0; m_sel = 0; m_mode = 0; m_pre = 0;
    m_dn = 0; m_wave = 0; m_fo = 0; m_fc = 0; m_mo = 0; m_mc = 0;
    p1 = 0; p2 = 0; p3 = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit t, wc, adv, match, top, bot, so, sc, nd, nw;
      int nc, na;
      wc = wr_en && wr_addr == 3'd1;
      case (m_sel)
        0: t = 0;
        1: t = 1;
        2: t = (m_pre % 8) == 7;
        3: t = (m_pre % 64) == 63;
        4: t = (m_pre % 256) == 255;
        5: t = (m_pre % 1024) == 1023;
        6: t = !p2 && p3;
        default: t = p2 && !p3;
      endcase
      m_pre = (m_pre + 1) % 1024;
      p3 = p2; p2 = p1; p1 = ext_evt;
      adv = t && !wc;
      match = adv && (m_cnt == m_act);
      top = (m_mode == 3) && !m_dn && m_cnt == 255;
      bot = (m_mode == 3) && m_dn && m_cnt == 0;
      so = 0; sc = match; nc = m_cnt; nd = m_dn; nw = m_wave; na = m_act;
      if (adv) begin
        if (m_mode == 0) begin
          nc = (m_cnt + 1) % 256; so = (m_cnt == 255);
        end else if (m_mode == 3) begin
          if (top)      begin nc = 254; nd = 1; na = m_buf; end
          else if (bot) begin nc = 1; nd = 0; so = 1; end
          else          nc = m_dn ? m_cnt - 1 : m_cnt + 1;
          if (match) nw = m_dn;
        end else begin
          if (match) nc = 0;
          else begin nc = (m_cnt + 1) % 256; so = (m_cnt == 255); end
          if (match && m_mode == 2) nw = !m_wave;
        end
      end
      if (m_mode != 3) nd = 0;
      if (wc) nc = wr_data;
      if (wr_en && wr_addr == 3'd2) begin
        if (m_mode != 3) na = wr_data;
        m_buf = wr_data;
      end
      if (wr_en && wr_addr == 3'd3) begin
        if (wr_data[0]) m_fo = 0;
        if (wr_data[1]) m_fc = 0;
      end
      m_fo = m_fo | so; m_fc = m_fc | sc;
      if (wr_en && wr_addr == 3'd4) begin m_mo = wr_data[0]; m_mc = wr_data[1]; end
      if (wr_en && wr_addr == 3'd0) begin m_sel = wr_data[2:0]; m_mode = wr_data[4:3]; end
      m_cnt = nc; m_dn = nd; m_wave = nw; m_act = na;
    end
  end

  // compare every cycle, half a cycle after the producing edge
  always @(negedge clk) begin
    if (!done) begin
      logic [12:0] a, e;
      a = {count_o, wave_o, ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o};
      e = {8'(m_cnt), m_wave, m_fo, m_fc, m_fo & m_mo, m_fc & m_mc};
      n_vec++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s t=%0t actual=%h expected=%h (count,wave,fo,fc,io,ic)", phase, $time, a, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      run(gap); ext_evt = ~ext_evt;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    run(3);
    // R1 explicit reset state
    n_vec++;
    if ({count_o, wave_o, ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o} !== 13'd0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h expected=0",
               {count_o, wave_o, ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o});
    end
    rst_n = 1;
    phase = "R2 stopped"; run(10);
    phase = "R12 load";  wr(3'd1, 8'd250); run(4);
    phase = "R4 wrap";   wr(3'd0, 8'h01); run(20);
    phase = "R11 R13";   wr(3'd4, 8'h03); run(3); wr(3'd3, 8'h01); run(2);
    wr(3'd3, 8'h02); run(2); wr(3'd4, 8'h01); run(300);
    phase = "R5";        wr(3'd2, 8'd40); run(300);
    phase = "R2 div";
    for (int s = 2; s <= 5; s++) begin
      wr(3'd0, 8'(s)); run(s == 5 ? 2200 : 600);
    end
    phase = "R2 stop";   wr(3'd0, 8'h00); run(40);
    phase = "R6";        wr(3'd1, 8'd0); wr(3'd2, 8'd10); wr(3'd0, 8'h09); run(60);
    phase = "R12 race";  wr(3'd1, 8'd5); run(20); wr(3'd1, 8'd255); run(5);
    phase = "R7";        wr(3'd0, 8'h11); run(60); wr(3'd0, 8'h12); run(300);
    phase = "R8 R9";     wr(3'd1, 8'd0); wr(3'd2, 8'd100); wr(3'd0, 8'h19); run(600);
    phase = "R10";       wr(3'd2, 8'd200); run(600); wr(3'd2, 8'd0); run(600);
    wr(3'd2, 8'd255); run(600);
    phase = "R9 hold";   wr(3'd0, 8'h01); wr(3'd2, 8'd3); run(40);
    phase = "R3 rise";   wr(3'd0, 8'h07); pulses(40, 4); run(6);
    phase = "R3 fall";   wr(3'd0, 8'h06); pulses(40, 3); run(6);
    phase = "R3 narrow"; for (int i = 0; i < 10; i++) begin ext_evt = 1; run(1); ext_evt = 0; run(5); end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule